// File: doc/BRIEF.md
# Six-Channel Buffered PWM Timebase

This block produces six raw pulse-width waveforms from one shared 16-bit timebase. The timebase counts either as a sawtooth (up from zero to the period value, then back to zero) or as a triangle (up to the period value and back down to zero). Each channel output stays high while the count is below that channel's duty value. The count advances on a single-cycle enable. A divider makes this enable from either the system clock or an external timer tick, with a ratio that is a power of two.

Software reaches the block through a plain register write port. The period and the duty values are written into shadow copies. They move into the working registers only after a load request, and only at a period boundary, so a waveform is never changed in the middle of a period. A sticky period flag and a one-cycle interrupt pulse report timebase events. The interrupt source and the slope it fires on can both be selected. A group mode makes channels 2 to 5 reuse the duty values of channels 0 and 1. Even channels follow channel 0 and odd channels follow channel 1. The outputs feed later dead-time and pin logic, which is not part of this block.

The write port has no back-pressure. Every write with `cfg_we` high is taken in the same clock. Register addresses: 0 control, 1 period shadow, 2 to 7 duty shadows for channels 0 to 5, 8 flag clear. Control bits: [0] run, [1] counter clear (one-shot), [2] load request, [3] triangle mode, [4] group mode, [5] tick source, [8:6] divider code, [10:9] interrupt source, [12:11] interrupt slope, [13] interrupt enable.

Top module: `pwm6_gen`

## Requirements
- R1: With control bit 3 low, the count steps 0,1,…,P and then returns to 0. One period is P+1 enables long, and the boundary event comes at the step from P to 0.
- R2: With control bit 3 high, the count steps 0,1,…,P,P-1,…,1 and back to 0. One period is 2P enables long. The boundary event is the enable taken at 0 while the count is falling, after which it rises again.
- R3: Writes to address 1 (period) and addresses 2 to 7 (duties) do not change the waveforms until a load request transfers them.
- R4: Writing control with bit 2 set requests a load. While running, the transfer happens at the next boundary event. While stopped (bit 0 low), it happens on the next clock. The request clears itself after the transfer, so later shadow writes wait for a new request.
- R5: Channel output k is high exactly when run is set and the count is below its effective duty value. A duty of 0 gives a constant low, and all outputs are low while stopped.
- R6: Divider code n in control bits [8:6] (0 to 7) lets one count enable through for every 2^n source ticks.
- R7: Control bit 5 low uses every system clock as the source tick. Bit 5 high uses only the cycles where `tmr_tick` is high, so the count holds while no tick arrives.
- R8: `period_flag` is set by every boundary event and stays set until a write to address 8 with bit 0 set. A set in the same clock wins over the clear.
- R9: `irq` pulses high for one clock after a qualifying event, but only when bit 13 is set. Source code 0 is the boundary event. Codes 1, 2 and 3 are an enable taken while the count equals the effective duty of channel 0, 2 or 4. Slope code 1 keeps only rising-count events, code 2 keeps only falling-count events (triangle mode only), and codes 0 and 3 keep both.
- R10: With control bit 4 high, channels 2 and 4 use the working duty of channel 0, and channels 3 and 5 use that of channel 1.
- R11: A control write with bit 1 set forces the count to 0 and the direction to rising in that clock.
- R12: With run low, the count holds its value and no boundary event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_tick | input | 1 | External timer overflow tick, one clock wide |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| pg | output | 6 | Raw channel waveforms, bit k is channel k |
| period_flag | output | 1 | Sticky period boundary flag |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The bench counts the high cycles of each channel over exactly one timebase period. It does this for sawtooth and triangle timing with duty values of zero, equal to the period, and above the period. A design that is off by one at the turning points would show counts wrong by one or two. Shadow writes are made while the timebase runs, with and without a load request, and again after a load has completed. These catch a design that bypasses the shadow copies or never clears its request. The bench also checks interrupt pulse counts per slope filter, where a wrong direction tag doubles or removes pulses. It checks that the timer-tick source freezes the count when no ticks arrive, and that group mode takes its duty from the shared channels.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

  // Register addresses (duty registers follow contiguously from DUTY_BASE)
  localparam int unsigned CTRL_ADDR  = 0;
  localparam int unsigned PER_ADDR   = 1;
  localparam int unsigned DUTY_BASE  = 2;

  // Control word bit positions
  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_CLR    = 1;
  localparam int unsigned B_LOAD   = 2;
  localparam int unsigned B_CENTER = 3;
  localparam int unsigned B_GROUP  = 4;
  localparam int unsigned B_TSEL   = 5;
  localparam int unsigned B_DIV    = 6;
  localparam int unsigned B_SRC    = 9;
  localparam int unsigned B_SLOPE  = 11;
  localparam int unsigned B_IEN    = 13;

  localparam int unsigned DIV_W = 3;

  typedef enum logic [1:0] {
    SLOPE_BOTH  = 2'd0,
    SLOPE_RISE  = 2'd1,
    SLOPE_FALL  = 2'd2,
    SLOPE_BOTH2 = 2'd3
  } slope_e;

  typedef struct packed {
    logic             run;
    logic             center;
    logic             group;
    logic             tsel;
    logic [DIV_W-1:0] div;
    logic [1:0]       src;
    slope_e           slope;
    logic             ien;
  } ctrl_t;

endpackage

// File: rtl/pwm6_prescale.sv
module pwm6_prescale #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tsel,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             ce
);

  localparam int unsigned PRE_W = (1 << DIV_W) - 1;

  logic             src_tick;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // Source tick: every clock, or only the external timer pulses
  assign src_tick = tsel ? tick : 1'b1;

  // Low div bits of the counter must all be ones for an enable
  assign mask = PRE_W'((32'd1 << div) - 32'd1);
  assign ce   = run & src_tick & ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
    end else if (src_tick) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  // R6: with a divide ratio above one, enables are never back to back
  a_r6_ce_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && div != '0) |=> (!ce || div == '0))
    else $error("R6: consecutive count enables with divider active");

endmodule

// File: rtl/pwm6_counter.sv
module pwm6_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             clr,
  input  logic             center,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             down,
  output logic             bnd
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    bnd    = 1'b0;
    if (ce) begin
      if (!center) begin
        // sawtooth
        down_d = 1'b0;
        if (cnt_q >= period) begin
          cnt_d = '0;
          bnd   = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else if (!down_q) begin
        // triangle, rising slope
        if (cnt_q >= period) begin
          down_d = 1'b1;
          cnt_d  = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        // triangle, falling slope
        if (cnt_q == '0) begin
          down_d = 1'b0;
          bnd    = 1'b1;
          cnt_d  = (period == '0) ? '0 : CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
    if (clr) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt  = cnt_q;
  assign down = down_q;

  // R1: below the period, a sawtooth enable advances the count by one
  a_r1_edge_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !clr && !center && cnt_q < period) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)))
    else $error("R1: sawtooth step wrong");

  // R2: the falling slope turns to rising at zero
  a_r2_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && center && down_q && cnt_q == '0) |=> !down_q)
    else $error("R2: triangle did not turn at zero");

  // R11: clear forces zero and rising direction
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !down_q))
    else $error("R11: clear did not reset counter");

  // R12: without an enable the count holds
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !clr) |=> $stable(cnt_q))
    else $error("R12: counter moved without enable");

endmodule

// File: rtl/pwm6_regs.sv
module pwm6_regs
  import pwm6_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NCH    = 6,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CNT_W-1:0]          wdata,
  input  logic                      bnd,
  output ctrl_t                     ctrl,
  output logic                      clr_pulse,
  output logic                      flag_clr,
  output logic [CNT_W-1:0]          per_act,
  output logic [NCH-1:0][CNT_W-1:0] duty_act
);

  localparam int unsigned FLAG_ADDR = DUTY_BASE + NCH;

  ctrl_t                     ctrl_q;
  logic [CNT_W-1:0]          per_buf;
  logic [NCH-1:0][CNT_W-1:0] duty_buf;
  logic                      load_pend;
  logic                      ctrl_we;
  logic                      load_set;
  logic                      xfer;

  assign ctrl_we   = we && (addr == ADDR_W'(CTRL_ADDR));
  assign load_set  = ctrl_we && wdata[B_LOAD];
  assign clr_pulse = ctrl_we && wdata[B_CLR];
  assign flag_clr  = we && (addr == ADDR_W'(FLAG_ADDR)) && wdata[0];
  assign xfer      = load_pend && (bnd || !ctrl_q.run);

  // Control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.run    <= wdata[B_RUN];
      ctrl_q.center <= wdata[B_CENTER];
      ctrl_q.group  <= wdata[B_GROUP];
      ctrl_q.tsel   <= wdata[B_TSEL];
      ctrl_q.div    <= wdata[B_DIV +: DIV_W];
      ctrl_q.src    <= wdata[B_SRC +: 2];
      ctrl_q.slope  <= slope_e'(wdata[B_SLOPE +: 2]);
      ctrl_q.ien    <= wdata[B_IEN];
    end
  end

  // Load request: set by software, cleared by the transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pend <= 1'b0;
    end else begin
      load_pend <= load_set | (load_pend & ~xfer);
    end
  end

  // Shadow period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf <= '0;
    end else if (we && addr == ADDR_W'(PER_ADDR)) begin
      per_buf <= wdata;
    end
  end

  // Shadow and working duty registers, one slice per channel
  for (genvar k = 0; k < NCH; k++) begin : g_duty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_buf[k] <= '0;
      end else if (we && addr == ADDR_W'(DUTY_BASE + k)) begin
        duty_buf[k] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_act[k] <= '0;
      end else if (xfer) begin
        duty_act[k] <= duty_buf[k];
      end
    end
  end

  // Working period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act <= '0;
    end else if (xfer) begin
      per_act <= per_buf;
    end
  end

  assign ctrl = ctrl_q;

  // R4: the request is gone after a transfer unless renewed
  a_r4_load_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !load_set) |=> !load_pend)
    else $error("R4: load request not cleared");

  // R3: working period only changes through a transfer
  a_r3_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(per_act))
    else $error("R3: working period changed without load");

  // R3: working duties only change through a transfer
  a_r3_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(duty_act))
    else $error("R3: working duty changed without load");

endmodule

// File: rtl/pwm6_events.sv
module pwm6_events
  import pwm6_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NCH   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce,
  input  logic                      bnd,
  input  logic                      falling,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [NCH-1:0][CNT_W-1:0] duty_eff,
  input  logic [1:0]                src,
  input  slope_e                    slope,
  input  logic                      ien,
  input  logic                      flag_clr,
  output logic                      flag,
  output logic                      irq
);

  logic [CNT_W-1:0] match_duty;
  logic             hit;
  logic             slope_ok;
  logic             flag_q;
  logic             irq_q;

  // Source 1..3 compares against channel 0, 2 or 4
  always_comb begin
    match_duty = '0;
    for (int k = 0; k < NCH; k++) begin
      if (src != 2'd0 && k == 2 * int'(src) - 2) begin
        match_duty = duty_eff[k];
      end
    end
  end

  assign hit = (src == 2'd0) ? bnd : (ce && cnt == match_duty);

  always_comb begin
    unique case (slope)
      SLOPE_RISE: slope_ok = !falling;
      SLOPE_FALL: slope_ok = falling;
      default:    slope_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= bnd | (flag_q & ~flag_clr);
      irq_q  <= ien & hit & slope_ok;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  // R8: a boundary always leaves the flag set
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> flag_q)
    else $error("R8: flag not set on boundary");

  // R8: flag is sticky without a clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q)
    else $error("R8: flag dropped without clear");

  // R9: no interrupt while disabled
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |=> !irq_q)
    else $error("R9: interrupt while disabled");

  // R9: the interrupt is a single clock pulse per event
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ce && !bnd) |=> !irq_q)
    else $error("R9: interrupt held without event");

endmodule

// File: rtl/pwm6_gen.sv
module pwm6_gen
  import pwm6_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NCH    = 6,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic [NCH-1:0]    pg,
  output logic              period_flag,
  output logic              irq
);

  ctrl_t                     ctrl;
  logic                      clr_pulse;
  logic                      flag_clr;
  logic [CNT_W-1:0]          per_act;
  logic [NCH-1:0][CNT_W-1:0] duty_act;
  logic [NCH-1:0][CNT_W-1:0] duty_eff;
  logic                      ce;
  logic [CNT_W-1:0]          cnt;
  logic                      down;
  logic                      bnd;
  logic                      falling;

  pwm6_regs #(
    .CNT_W (CNT_W),
    .NCH   (NCH),
    .ADDR_W(ADDR_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .bnd      (bnd),
    .ctrl     (ctrl),
    .clr_pulse(clr_pulse),
    .flag_clr (flag_clr),
    .per_act  (per_act),
    .duty_act (duty_act)
  );

  pwm6_prescale #(
    .DIV_W(DIV_W)
  ) pre_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl.run),
    .tsel (ctrl.tsel),
    .tick (tmr_tick),
    .div  (ctrl.div),
    .ce   (ce)
  );

  pwm6_counter #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .clr   (clr_pulse),
    .center(ctrl.center),
    .period(per_act),
    .cnt   (cnt),
    .down  (down),
    .bnd   (bnd)
  );

  // Direction tag for event filtering: sawtooth always counts as rising
  assign falling = ctrl.center & down;

  // Channel compare slices, with group remapping above channel 1
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g >= 2) begin : g_grp
      localparam int unsigned PAIR = g % 2;
      assign duty_eff[g] = ctrl.group ? duty_act[PAIR] : duty_act[g];
    end else begin : g_own
      assign duty_eff[g] = duty_act[g];
    end
    assign pg[g] = ctrl.run & (cnt < duty_eff[g]);
  end

  pwm6_events #(
    .CNT_W(CNT_W),
    .NCH  (NCH)
  ) ev_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .bnd     (bnd),
    .falling (falling),
    .cnt     (cnt),
    .duty_eff(duty_eff),
    .src     (ctrl.src),
    .slope   (ctrl.slope),
    .ien     (ctrl.ien),
    .flag_clr(flag_clr),
    .flag    (period_flag),
    .irq     (irq)
  );

  // R12: stopping leaves the boundary event silent
  a_r12_no_bnd_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |-> !bnd)
    else $error("R12: boundary while stopped");

endmodule

// File: tb/pwm6_gen_tb_top.sv
`timescale 1ns/1ps
module pwm6_gen_tb_top;

  localparam int NCH = 6;

  typedef struct packed {
    logic                ctr;
    logic                grp;
    logic [15:0]         per;
    logic [5:0][15:0]    duty;
    logic [5:0][15:0]    expc;
  } vec_t;

  // Duties and expected high counts listed channel 5 first, channel 0 last
  localparam vec_t VECS [4] = '{
    '{ctr:1'b0, grp:1'b0, per:16'd9,
      duty:{16'd5, 16'd15, 16'd10, 16'd9, 16'd0, 16'd3},
      expc:{16'd5, 16'd10, 16'd10, 16'd9, 16'd0, 16'd3}},
    '{ctr:1'b1, grp:1'b0, per:16'd8,
      duty:{16'd2, 16'd9, 16'd8, 16'd0, 16'd1, 16'd4},
      expc:{16'd3, 16'd16, 16'd15, 16'd0, 16'd1, 16'd7}},
    '{ctr:1'b0, grp:1'b1, per:16'd7,
      duty:{16'd100, 16'd100, 16'd100, 16'd100, 16'd6, 16'd2},
      expc:{16'd6, 16'd2, 16'd6, 16'd2, 16'd6, 16'd2}},
    '{ctr:1'b1, grp:1'b1, per:16'd5,
      duty:{16'd0, 16'd0, 16'd0, 16'd0, 16'd3, 16'd5},
      expc:{16'd5, 16'd9, 16'd5, 16'd9, 16'd5, 16'd9}}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [NCH-1:0] pg;
  logic        period_flag;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit tick_on = 1'b0;
  int tick_ph = 0;
  int hi [NCH];
  int irqs;

  always #2.5 clk = ~clk;

  pwm6_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_tick   (tmr_tick),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .pg         (pg),
    .period_flag(period_flag),
    .irq        (irq)
  );

  // Timer tick: one clock high out of every three when enabled
  always @(negedge clk) begin
    if (tick_on) begin
      tmr_tick <= (tick_ph == 0);
      tick_ph  <= (tick_ph == 2) ? 0 : tick_ph + 1;
    end else begin
      tmr_tick <= 1'b0;
      tick_ph  <= 0;
    end
  end

  function automatic logic [15:0] cw(bit run, bit clr, bit ld, bit ctr, bit grp,
                                     bit ts, int dv, int src, int slp, bit ien);
    logic [15:0] w;
    w        = '0;
    w[0]     = run;
    w[1]     = clr;
    w[2]     = ld;
    w[3]     = ctr;
    w[4]     = grp;
    w[5]     = ts;
    w[8:6]   = 3'(dv);
    w[10:9]  = 2'(src);
    w[12:11] = 2'(slp);
    w[13]    = ien;
    return w;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 4'(a);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(int n);
    for (int c = 0; c < NCH; c++) hi[c] = 0;
    irqs = 0;
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pg[c]) hi[c]++;
      if (irq) irqs++;
    end
  endtask

  // Stop, clear, fill shadows, load while stopped, then run
  task automatic cfg(bit ctr, bit grp, int per, logic [5:0][15:0] d, logic [15:0] extra);
    wr(0, cw(0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(1, 16'(per));
    for (int k = 0; k < NCH; k++) wr(2 + k, d[k]);
    wr(0, cw(0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    idle(2);
    wr(0, cw(1, 0, 0, ctr, grp, 0, 0, 0, 0, 0) | extra);
    wr(8, 16'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0][15:0] d;
    idle(3);
    // Reset state
    check("R5 reset pg", int'(pg), 0);
    check("R8 reset flag", int'(period_flag), 0);
    check("R9 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    idle(2);

    // Table walk: waveform high counts over one full period (R1 R2 R5 R10)
    for (int v = 0; v < 4; v++) begin
      int win;
      cfg(VECS[v].ctr, VECS[v].grp, int'(VECS[v].per), VECS[v].duty, 16'd0);
      idle(40);
      win = VECS[v].ctr ? 2 * int'(VECS[v].per) : int'(VECS[v].per) + 1;
      measure(win);
      for (int c = 0; c < NCH; c++)
        check(VECS[v].ctr ? "R2 triangle high count" : "R1 sawtooth high count",
              hi[c], int'(VECS[v].expc[c]));
    end

    // R3 / R4: shadow writes while running
    d = {16'd5, 16'd15, 16'd10, 16'd9, 16'd0, 16'd3};
    cfg(0, 0, 9, d, 16'd0);
    idle(30);
    wr(2, 16'd7);
    idle(30);
    measure(10);
    check("R3 duty shadow not applied", hi[0], 3);
    wr(0, cw(1, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    idle(30);
    measure(10);
    check("R4 load applied at boundary", hi[0], 7);
    wr(2, 16'd1);
    wr(1, 16'd4);
    idle(30);
    measure(10);
    check("R4 request self-cleared duty", hi[0], 7);
    check("R3 period shadow not applied", hi[2], 9);

    // R11: clear forces count zero (duty0 = 1 is high only at zero)
    wr(0, cw(1, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    wr(1, 16'd9);
    wr(0, cw(1, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    idle(40);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = cw(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11 count zero after clear", int'(pg[0]), 1);
    @(negedge clk);
    check("R11 count advanced after clear", int'(pg[0]), 0);

    // R8 flag set while running, R5 / R12 stop behaviour
    idle(20);
    check("R8 flag set by boundary", int'(period_flag), 1);
    wr(0, cw(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    check("R5 outputs low when stopped", int'(pg), 0);
    wr(8, 16'd1);
    check("R8 flag cleared", int'(period_flag), 0);
    idle(30);
    check("R12 no boundary while stopped", int'(period_flag), 0);

    // R6: divider code 2 -> enable every 4 clocks
    d = {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2};
    cfg(0, 0, 3, d, cw(0, 0, 0, 0, 0, 0, 2, 0, 0, 0));
    idle(40);
    measure(16);
    check("R6 divide by 4", hi[0], 8);
    d = {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd1};
    cfg(0, 0, 1, d, cw(0, 0, 0, 0, 0, 0, 7, 0, 0, 0));
    idle(300);
    measure(256);
    check("R6 divide by 128", hi[0], 128);

    // R7: timer tick source
    d = {16'd0, 16'd0, 16'd0, 16'd0, 16'd1, 16'd2};
    cfg(0, 0, 3, d, cw(0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
    measure(20);
    check("R7 frozen without ticks ch0", hi[0], 20);
    check("R7 frozen without ticks ch1", hi[1], 20);
    tick_on = 1'b1;
    idle(30);
    measure(12);
    check("R7 tick source ch0", hi[0], 6);
    check("R7 tick source ch1", hi[1], 3);
    tick_on = 1'b0;

    // R9: interrupt sources and slopes
    d = {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0};
    cfg(0, 0, 4, d, cw(0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    idle(20);
    measure(20);
    check("R9 boundary irq sawtooth", irqs, 4);
    d = {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3};
    cfg(1, 0, 5, d, cw(0, 0, 0, 0, 0, 0, 0, 1, 2, 1));
    idle(20);
    measure(20);
    check("R9 match falling only", irqs, 2);
    wr(0, cw(1, 0, 0, 1, 0, 0, 0, 1, 1, 1));
    idle(20);
    measure(20);
    check("R9 match rising only", irqs, 2);
    wr(0, cw(1, 0, 0, 1, 0, 0, 0, 1, 0, 1));
    idle(20);
    measure(20);
    check("R9 match both slopes", irqs, 4);
    wr(0, cw(1, 0, 0, 1, 0, 0, 0, 0, 1, 1));
    idle(20);
    measure(20);
    check("R9 triangle boundary rising filter", irqs, 0);
    wr(0, cw(1, 0, 0, 1, 0, 0, 0, 0, 2, 1));
    idle(20);
    measure(20);
    check("R9 triangle boundary falling filter", irqs, 2);
    wr(0, cw(1, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    idle(20);
    measure(20);
    check("R9 disabled irq", irqs, 0);

    // R10: group mode feeds channel 2 match from channel 0 duty
    wr(0, cw(1, 0, 0, 1, 1, 0, 0, 2, 0, 1));
    idle(20);
    measure(20);
    check("R10 group duty on irq source ch2", irqs, 4);
    check("R10 group ch2 high count", hi[2], 10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule